// File: doc/BRIEF.md
# Page-Table Capability Permission Checker

This block judges one leaf page-table entry against one memory access during a page-table walk. It first applies the ordinary privilege and page permission rules: read, write and execute rights, the user-page bit, the make-executable-readable option and the supervisor-user-access option. After that it applies a layer of rules that only concern capability traffic. A 10-bit extension field in the entry can forbid tagged capability stores. For capability loads, the same field chooses whether the load proceeds, has its tag cleared, or traps. In the trap-or-proceed case the choice can depend on a per-page generation bit, which is compared with a global generation bit held in a control register.

The walker presents the entry, the access description, the privilege, two control register values and the load-policy accumulator it has built up so far. One cycle later the block returns one verdict: invalid entry, pass, fail with a cause, or internal error. It also returns the updated accumulator. Two parameters select the variant. One says whether the entry carries a real extension field; narrow translation schemes have no spare bits, so a fixed field is used. The other says whether supervisor mode exists, which decides which control register supplies the generation bits.

Top module: `ptecap_check`

## Requirements
- R1: While rst_n is low, out_valid, every verdict flag and acc_out are 0, and they stay 0 until the first accepted request.
- R2: A request with in_valid=1 produces out_valid=1 on the next clock edge, with exactly one of out_invalid, out_pass, out_fail, out_ierr set. A cycle with in_valid=0 produces out_valid=0 on the next edge.
- R3: The entry is invalid (out_invalid=1) if any of the following holds: V=0; W=1 with R=0; read-enable=0 with generation=1; or read-enable=1 with generation=1 and read-trap=0. The extension field positions are: store-enable bit 9, read-enable bit 8, dirty bit 7, read-trap bit 6, generation bit 5. Bits 4..0 are unused.
- R4: The op codes are 0 execute, 1 read, 2 write and 3 read-modify-write. The privilege codes are 0 user and 1 supervisor. The base permission rules are as follows. For a user request, U=1 is required. For a supervisor request, U=0 or SUM=1 is required, except that execute requires U=0. On top of that, read needs R or (X and MXR), write needs W, read-modify-write needs both, and execute needs X. A failure gives out_fail=1 with out_cap_err=0, and this failure takes precedence over any capability check.
- R5: After the base check succeeds, a write or read-modify-write whose stored item is a capability (wr_is_cap=1) fails with out_cap_err=1 when the store-enable bit is 0. The store check is decided before the load policy.
- R6: For a passing read or read-modify-write whose loaded item is a capability (rd_is_cap=1), the page policy is chosen from (read-enable, read-trap, generation): (0,0,0) gives CLEAR, (0,1,0) gives TRAP, and (1,0,0) gives OK. The policy codes are 0 OK, 1 CLEAR and 2 TRAP.
- R7: When read-enable=1 and read-trap=1, the generation bit is compared with a global bit. The global bit is control bit 3 when the entry's U=1 and control bit 2 when U=0, whatever the current privilege. If the bits are equal the policy is OK; otherwise it is TRAP.
- R8: With HAS_SUP=1 the global bits come from sup_ctrl; with HAS_SUP=0 they come from mach_ctrl.
- R9: acc_out is the more severe of acc_in and the page policy, with TRAP above CLEAR above OK, so an OK policy leaves the accumulator as it was. Where no policy applies (invalid, fail, internal error, or a non-capability load), acc_out equals acc_in. An acc_in of 3 is read as TRAP.
- R10: With EXT_PRESENT=0 the pte_ext input is ignored and the field is taken as store-enable=1, read-enable=1, dirty=1, read-trap=0, generation=0.
- R11: A privilege code of 2 or 3 is not a legal request. It gives out_ierr=1, takes precedence over every other verdict, and passes acc_in through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| pte_v | input | 1 | Entry valid bit |
| pte_r | input | 1 | Entry read bit |
| pte_w | input | 1 | Entry write bit |
| pte_x | input | 1 | Entry execute bit |
| pte_u | input | 1 | Entry user-page bit |
| pte_ext | input | EXT_W | Capability extension field |
| op | input | 2 | Access kind |
| rd_is_cap | input | 1 | Loaded item is a capability |
| wr_is_cap | input | 1 | Stored item is a capability |
| priv | input | 2 | Current privilege |
| mxr | input | 1 | Executable pages readable |
| sum | input | 1 | Supervisor may touch user pages |
| sup_ctrl | input | CTRL_W | Supervisor capability control register |
| mach_ctrl | input | CTRL_W | Machine capability control register |
| acc_in | input | 2 | Incoming load-policy accumulator |
| out_valid | output | 1 | Verdict present |
| out_invalid | output | 1 | Entry malformed |
| out_pass | output | 1 | Access permitted |
| out_fail | output | 1 | Access refused |
| out_cap_err | output | 1 | Refusal is a capability error |
| out_ierr | output | 1 | Illegal privilege on input |
| acc_out | output | 2 | Updated load-policy accumulator |

## Verification
The bench builds three copies of the block. The first uses the default parameters (EXT_PRESENT=1, HAS_SUP=1). The second uses HAS_SUP=0, so the generation comparison reads mach_ctrl while sup_ctrl is driven with unrelated values. The third uses EXT_PRESENT=0, so random extension fields must have no effect. All three receive the same directed and seeded random requests. Together they reach every policy row, both sources of the global bit, and the fixed-field variant.

// File: rtl/ptecap_pkg.sv
package ptecap_pkg;

    localparam logic [1:0] OP_EXEC  = 2'd0;
    localparam logic [1:0] OP_READ  = 2'd1;
    localparam logic [1:0] OP_WRITE = 2'd2;
    localparam logic [1:0] OP_RMW   = 2'd3;

    localparam logic [1:0] PRV_USER = 2'd0;
    localparam logic [1:0] PRV_SUP  = 2'd1;

    localparam logic [1:0] POL_OK    = 2'd0;
    localparam logic [1:0] POL_CLEAR = 2'd1;
    localparam logic [1:0] POL_TRAP  = 2'd2;

    typedef struct packed {
        logic       valid;
        logic       inv;
        logic       pass;
        logic       fail;
        logic       cap_err;
        logic       ierr;
        logic [1:0] acc;
    } verdict_t;

    // Code 3 is not a legal accumulator value; it is treated as the worst case.
    function automatic logic [1:0] pol_norm(input logic [1:0] p);
        return (p == 2'd3) ? POL_TRAP : p;
    endfunction

    function automatic logic [1:0] pol_join(input logic [1:0] a, input logic [1:0] b);
        logic [1:0] na;
        logic [1:0] nb;
        na = pol_norm(a);
        nb = pol_norm(b);
        return (na > nb) ? na : nb;
    endfunction

endpackage

// File: rtl/ptecap_field_src.sv
module ptecap_field_src #(
    parameter int EXT_W       = 10,
    parameter int CTRL_W      = 4,
    parameter bit EXT_PRESENT = 1'b1,
    parameter bit HAS_SUP     = 1'b1
) (
    input  logic [EXT_W-1:0]  pte_ext,
    input  logic [CTRL_W-1:0] sup_ctrl,
    input  logic [CTRL_W-1:0] mach_ctrl,
    output logic              cap_wr_en,
    output logic              cap_rd_en,
    output logic              cap_rd_trap,
    output logic              cap_rd_gen,
    output logic              gen_user,
    output logic              gen_sys
);
    localparam int CW_POS  = EXT_W - 1;
    localparam int CR_POS  = EXT_W - 2;
    localparam int CD_POS  = EXT_W - 3;
    localparam int CRT_POS = EXT_W - 4;
    localparam int CRG_POS = EXT_W - 5;
    localparam int UGEN_BIT = 3;
    localparam int SGEN_BIT = 2;
    localparam logic [EXT_W-1:0] FIXED_EXT =
        (EXT_W'(1) << CW_POS) | (EXT_W'(1) << CR_POS) | (EXT_W'(1) << CD_POS);

    logic [EXT_W-1:0]  ext_eff;
    logic [CTRL_W-1:0] ctrl_src;

    generate
        if (EXT_PRESENT) begin : g_ext_live
            assign ext_eff = pte_ext;
        end else begin : g_ext_fixed
            assign ext_eff = FIXED_EXT;
        end
        if (HAS_SUP) begin : g_ctrl_sup
            assign ctrl_src = sup_ctrl;
        end else begin : g_ctrl_mach
            assign ctrl_src = mach_ctrl;
        end
    endgenerate

    assign cap_wr_en   = ext_eff[CW_POS];
    assign cap_rd_en   = ext_eff[CR_POS];
    assign cap_rd_trap = ext_eff[CRT_POS];
    assign cap_rd_gen  = ext_eff[CRG_POS];
    assign gen_user    = ctrl_src[UGEN_BIT];
    assign gen_sys     = ctrl_src[SGEN_BIT];

    logic unused_sink;
    assign unused_sink = ^{pte_ext, ext_eff, sup_ctrl, mach_ctrl, ctrl_src};

endmodule

// File: rtl/ptecap_base_perm.sv
module ptecap_base_perm
    import ptecap_pkg::*;
(
    input  logic       pte_r,
    input  logic       pte_w,
    input  logic       pte_x,
    input  logic       pte_u,
    input  logic [1:0] op,
    input  logic [1:0] priv,
    input  logic       mxr,
    input  logic       sum,
    output logic       perm_ok,
    output logic       bad_priv
);
    logic readable;
    logic page_reach;
    logic exec_ok;

    always_comb begin
        readable = pte_r | (pte_x & mxr);
        bad_priv = priv[1];
        if (priv == PRV_USER) begin
            page_reach = pte_u;
            exec_ok    = pte_u & pte_x;
        end else begin
            page_reach = ~pte_u | sum;
            exec_ok    = ~pte_u & pte_x;
        end
        unique case (op)
            OP_EXEC:  perm_ok = exec_ok;
            OP_READ:  perm_ok = page_reach & readable;
            OP_WRITE: perm_ok = page_reach & pte_w;
            default:  perm_ok = page_reach & pte_w & readable;
        endcase
        if (bad_priv) begin
            perm_ok = 1'b0;
        end
    end

endmodule

// File: rtl/ptecap_ld_policy.sv
module ptecap_ld_policy
    import ptecap_pkg::*;
(
    input  logic       cap_rd_en,
    input  logic       cap_rd_trap,
    input  logic       cap_rd_gen,
    input  logic       pte_u,
    input  logic       gen_user,
    input  logic       gen_sys,
    input  logic [1:0] acc_in,
    output logic [1:0] acc_joined
);
    logic       gen_global;
    logic [1:0] page_pol;

    always_comb begin
        gen_global = pte_u ? gen_user : gen_sys;
        unique case ({cap_rd_en, cap_rd_trap})
            2'b00:   page_pol = POL_CLEAR;
            2'b01:   page_pol = POL_TRAP;
            2'b10:   page_pol = POL_OK;
            default: page_pol = (cap_rd_gen == gen_global) ? POL_OK : POL_TRAP;
        endcase
        acc_joined = pol_join(acc_in, page_pol);
    end

endmodule

// File: rtl/ptecap_check.sv
module ptecap_check
    import ptecap_pkg::*;
#(
    parameter int EXT_W       = 10,
    parameter int CTRL_W      = 4,
    parameter bit EXT_PRESENT = 1'b1,
    parameter bit HAS_SUP     = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              pte_v,
    input  logic              pte_r,
    input  logic              pte_w,
    input  logic              pte_x,
    input  logic              pte_u,
    input  logic [EXT_W-1:0]  pte_ext,
    input  logic [1:0]        op,
    input  logic              rd_is_cap,
    input  logic              wr_is_cap,
    input  logic [1:0]        priv,
    input  logic              mxr,
    input  logic              sum,
    input  logic [CTRL_W-1:0] sup_ctrl,
    input  logic [CTRL_W-1:0] mach_ctrl,
    input  logic [1:0]        acc_in,
    output logic              out_valid,
    output logic              out_invalid,
    output logic              out_pass,
    output logic              out_fail,
    output logic              out_cap_err,
    output logic              out_ierr,
    output logic [1:0]        acc_out
);
    logic       cap_wr_en;
    logic       cap_rd_en;
    logic       cap_rd_trap;
    logic       cap_rd_gen;
    logic       gen_user;
    logic       gen_sys;
    logic       perm_ok;
    logic       bad_priv;
    logic [1:0] acc_joined;
    logic       malformed;
    logic       store_cap;
    logic       load_cap;

    verdict_t res_d;
    verdict_t res_q;

    ptecap_field_src #(
        .EXT_W      (EXT_W),
        .CTRL_W     (CTRL_W),
        .EXT_PRESENT(EXT_PRESENT),
        .HAS_SUP    (HAS_SUP)
    ) u_src (
        .pte_ext    (pte_ext),
        .sup_ctrl   (sup_ctrl),
        .mach_ctrl  (mach_ctrl),
        .cap_wr_en  (cap_wr_en),
        .cap_rd_en  (cap_rd_en),
        .cap_rd_trap(cap_rd_trap),
        .cap_rd_gen (cap_rd_gen),
        .gen_user   (gen_user),
        .gen_sys    (gen_sys)
    );

    ptecap_base_perm u_base (
        .pte_r   (pte_r),
        .pte_w   (pte_w),
        .pte_x   (pte_x),
        .pte_u   (pte_u),
        .op      (op),
        .priv    (priv),
        .mxr     (mxr),
        .sum     (sum),
        .perm_ok (perm_ok),
        .bad_priv(bad_priv)
    );

    ptecap_ld_policy u_ld (
        .cap_rd_en  (cap_rd_en),
        .cap_rd_trap(cap_rd_trap),
        .cap_rd_gen (cap_rd_gen),
        .pte_u      (pte_u),
        .gen_user   (gen_user),
        .gen_sys    (gen_sys),
        .acc_in     (acc_in),
        .acc_joined (acc_joined)
    );

    always_comb begin
        malformed = ~pte_v | (pte_w & ~pte_r)
                  | (~cap_rd_en & cap_rd_gen)
                  | (cap_rd_en & cap_rd_gen & ~cap_rd_trap);
        store_cap = wr_is_cap & ((op == OP_WRITE) | (op == OP_RMW));
        load_cap  = rd_is_cap & ((op == OP_READ) | (op == OP_RMW));

        res_d       = '0;
        res_d.valid = in_valid;
        res_d.acc   = pol_norm(acc_in);
        if (in_valid) begin
            if (bad_priv) begin
                res_d.ierr = 1'b1;
            end else if (malformed) begin
                res_d.inv = 1'b1;
            end else if (!perm_ok) begin
                res_d.fail = 1'b1;
            end else if (store_cap && !cap_wr_en) begin
                res_d.fail    = 1'b1;
                res_d.cap_err = 1'b1;
            end else begin
                res_d.pass = 1'b1;
                if (load_cap) begin
                    res_d.acc = acc_joined;
                end
            end
        end else begin
            res_d.acc = res_q.acc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid   = res_q.valid;
    assign out_invalid = res_q.inv;
    assign out_pass    = res_q.pass;
    assign out_fail    = res_q.fail;
    assign out_cap_err = res_q.cap_err;
    assign out_ierr    = res_q.ierr;
    assign acc_out     = res_q.acc;

endmodule

// File: rtl/ptecap_check_sva.sv
module ptecap_check_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       pte_v,
    input logic [1:0] op,
    input logic       wr_is_cap,
    input logic [1:0] priv,
    input logic [1:0] acc_in,
    input logic       out_valid,
    input logic       out_invalid,
    input logic       out_pass,
    input logic       out_fail,
    input logic       out_cap_err,
    input logic       out_ierr,
    input logic [1:0] acc_out
);
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && acc_out == 2'd0));

    a_r2_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $countones({out_invalid, out_pass, out_fail, out_ierr}) == 1);

    a_r2_follows_request: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r11_bad_priv: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && priv[1]) |=> out_ierr);

    a_r3_v_clear_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !priv[1] && !pte_v && acc_in != 2'd3)
            |=> (out_invalid && acc_out == $past(acc_in)));

    a_r5_caperr_needs_capstore: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !(wr_is_cap && op[1])) |=> !out_cap_err);

    a_r9_never_weakens: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && acc_in != 2'd3) |=> acc_out >= $past(acc_in));

endmodule

bind ptecap_check ptecap_check_sva u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .pte_v      (pte_v),
    .op         (op),
    .wr_is_cap  (wr_is_cap),
    .priv       (priv),
    .acc_in     (acc_in),
    .out_valid  (out_valid),
    .out_invalid(out_invalid),
    .out_pass   (out_pass),
    .out_fail   (out_fail),
    .out_cap_err(out_cap_err),
    .out_ierr   (out_ierr),
    .acc_out    (acc_out)
);

// File: tb/ptecap_check_test.sv
`timescale 1ns/1ps
module ptecap_check_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       pte_v = 1'b0, pte_r = 1'b0, pte_w = 1'b0, pte_x = 1'b0, pte_u = 1'b0;
    logic [9:0] pte_ext = '0;
    logic [1:0] op = '0;
    logic       rd_is_cap = 1'b0, wr_is_cap = 1'b0;
    logic [1:0] priv = '0;
    logic       mxr = 1'b0, sum = 1'b0;
    logic [3:0] sup_ctrl = '0, mach_ctrl = '0;
    logic [1:0] acc_in = '0;

    logic [2:0] o_valid, o_inv, o_pass, o_fail, o_cerr, o_ierr;
    logic [1:0] o_acc [3];

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    ptecap_check uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .pte_v(pte_v), .pte_r(pte_r), .pte_w(pte_w), .pte_x(pte_x), .pte_u(pte_u),
        .pte_ext(pte_ext), .op(op), .rd_is_cap(rd_is_cap), .wr_is_cap(wr_is_cap),
        .priv(priv), .mxr(mxr), .sum(sum), .sup_ctrl(sup_ctrl), .mach_ctrl(mach_ctrl),
        .acc_in(acc_in), .out_valid(o_valid[0]), .out_invalid(o_inv[0]),
        .out_pass(o_pass[0]), .out_fail(o_fail[0]), .out_cap_err(o_cerr[0]),
        .out_ierr(o_ierr[0]), .acc_out(o_acc[0])
    );

    ptecap_check #(.HAS_SUP(1'b0)) uut_msrc (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .pte_v(pte_v), .pte_r(pte_r), .pte_w(pte_w), .pte_x(pte_x), .pte_u(pte_u),
        .pte_ext(pte_ext), .op(op), .rd_is_cap(rd_is_cap), .wr_is_cap(wr_is_cap),
        .priv(priv), .mxr(mxr), .sum(sum), .sup_ctrl(sup_ctrl), .mach_ctrl(mach_ctrl),
        .acc_in(acc_in), .out_valid(o_valid[1]), .out_invalid(o_inv[1]),
        .out_pass(o_pass[1]), .out_fail(o_fail[1]), .out_cap_err(o_cerr[1]),
        .out_ierr(o_ierr[1]), .acc_out(o_acc[1])
    );

    ptecap_check #(.EXT_PRESENT(1'b0)) uut_fixed (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .pte_v(pte_v), .pte_r(pte_r), .pte_w(pte_w), .pte_x(pte_x), .pte_u(pte_u),
        .pte_ext(pte_ext), .op(op), .rd_is_cap(rd_is_cap), .wr_is_cap(wr_is_cap),
        .priv(priv), .mxr(mxr), .sum(sum), .sup_ctrl(sup_ctrl), .mach_ctrl(mach_ctrl),
        .acc_in(acc_in), .out_valid(o_valid[2]), .out_invalid(o_inv[2]),
        .out_pass(o_pass[2]), .out_fail(o_fail[2]), .out_cap_err(o_cerr[2]),
        .out_ierr(o_ierr[2]), .acc_out(o_acc[2])
    );

    // Expected {inv, pass, fail, cap_err, ierr, acc[1:0]} from the requirements.
    function automatic logic [6:0] model(input int variant);
        logic [9:0] e;
        logic [3:0] c;
        logic cw, cr, crt, crg, gbit, rdbl, reach, ok;
        logic [1:0] a, pol;
        e = (variant == 2) ? 10'b1110000000 : pte_ext;
        c = (variant == 1) ? mach_ctrl : sup_ctrl;
        cw = e[9]; cr = e[8]; crt = e[6]; crg = e[5];
        a = (acc_in == 2'd3) ? 2'd2 : acc_in;
        if (priv >= 2) return {5'b00001, a};
        if (!pte_v || (pte_w && !pte_r) || (!cr && crg) || (cr && crg && !crt))
            return {5'b10000, a};
        rdbl  = pte_r || (pte_x && mxr);
        reach = (priv == 0) ? pte_u : (!pte_u || sum);
        case (op)
            2'd0: ok = (priv == 0) ? (pte_u && pte_x) : (!pte_u && pte_x);
            2'd1: ok = reach && rdbl;
            2'd2: ok = reach && pte_w;
            default: ok = reach && pte_w && rdbl;
        endcase
        if (!ok) return {5'b00100, a};
        if (op >= 2 && wr_is_cap && !cw) return {5'b00110, a};
        if ((op == 1 || op == 3) && rd_is_cap) begin
            gbit = pte_u ? c[3] : c[2];
            if (!cr && !crt)     pol = 2'd1;
            else if (!cr)        pol = 2'd2;
            else if (!crt)       pol = 2'd0;
            else                 pol = (crg == gbit) ? 2'd0 : 2'd2;
            if (pol > a) a = pol;
        end
        return {5'b01000, a};
    endfunction

    function automatic string tag_of(input int variant, input logic [6:0] ex);
        if (variant == 2) return "R10";
        if (ex[2]) return "R11";
        if (ex[6]) return "R3";
        if (ex[4] && ex[3]) return "R5";
        if (ex[4]) return "R4";
        if ((op == 1 || op == 3) && rd_is_cap) begin
            if (pte_ext[8] && pte_ext[6]) return (variant == 1) ? "R8" : "R7";
            return (acc_in != 0) ? "R9" : "R6";
        end
        return "R4";
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_vec();
        logic [6:0] ex [3];
        for (int k = 0; k < 3; k++) ex[k] = model(k);
        @(negedge clk);
        in_valid = 1'b1;
        for (int k = 0; k < 3; k++) ex[k] = model(k);
        @(posedge clk);
        #1;
        for (int k = 0; k < 3; k++) begin
            check("R2", 16'(o_valid[k]), 16'd1);
            check(tag_of(k, ex[k]),
                  16'({o_inv[k], o_pass[k], o_fail[k], o_cerr[k], o_ierr[k], o_acc[k]}),
                  16'(ex[k]));
        end
    endtask

    task automatic set_pte(input logic v, r, w, x, u, input logic [9:0] e);
        pte_v = v; pte_r = r; pte_w = w; pte_x = x; pte_u = u; pte_ext = e;
    endtask

    task automatic set_acc(input logic [1:0] o, input logic rc, wc, input logic [1:0] p,
                           input logic [1:0] a);
        op = o; rd_is_cap = rc; wr_is_cap = wc; priv = p; acc_in = a;
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual hung expected finish");
        if (!done) begin
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        for (int k = 0; k < 3; k++)
            check("R1", 16'({o_valid[k], o_inv[k], o_pass[k], o_fail[k], o_ierr[k], o_acc[k]}), 16'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1", 16'({o_valid[0], o_acc[0]}), 16'd0);

        // Directed corners
        mxr = 0; sum = 0; sup_ctrl = 4'b1000; mach_ctrl = 4'b0100;
        set_pte(1,1,1,0,1, 10'b1100000000); set_acc(2'd1,1,0,2'd0,2'd0); run_vec(); // R6 OK
        set_pte(1,1,1,0,1, 10'b0000000000); set_acc(2'd1,1,0,2'd0,2'd0); run_vec(); // R6 CLEAR
        set_pte(1,1,1,0,1, 10'b0001000000); set_acc(2'd3,1,0,2'd0,2'd1); run_vec(); // R6 TRAP
        set_pte(1,1,1,0,1, 10'b1101100000); set_acc(2'd1,1,0,2'd0,2'd0); run_vec(); // R7 user gen
        set_pte(1,1,1,0,0, 10'b1101100000); set_acc(2'd1,1,0,2'd1,2'd0); run_vec(); // R7 sys gen
        set_pte(1,1,1,0,1, 10'b0100000000); set_acc(2'd2,0,1,2'd0,2'd0); run_vec(); // R5
        set_pte(1,1,0,0,1, 10'b0100000000); set_acc(2'd2,0,1,2'd0,2'd0); run_vec(); // R4 wins
        set_pte(1,0,1,0,1, 10'b1100000000); set_acc(2'd1,0,0,2'd0,2'd0); run_vec(); // R3
        set_pte(1,1,1,0,1, 10'b1100100000); set_acc(2'd1,1,0,2'd0,2'd1); run_vec(); // R3
        set_pte(1,1,1,1,1, 10'b1100000000); set_acc(2'd1,1,0,2'd3,2'd2); run_vec(); // R11
        set_pte(1,1,1,0,1, 10'b0000000000); set_acc(2'd1,1,0,2'd0,2'd2); run_vec(); // R9
        set_pte(1,0,0,1,0, 10'b1100000000); mxr = 1;
        set_acc(2'd1,0,0,2'd1,2'd0); run_vec(); // R4 mxr read
        set_acc(2'd0,0,0,2'd1,2'd0); run_vec(); // R4 sup exec
        mxr = 0;

        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        #1;
        check("R2", 16'(o_valid[0]), 16'd0);

        void'($urandom(32'd4242));
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom();
            set_pte(r[0] | r[1], r[2], r[3], r[4], r[5], 10'($urandom()));
            if (r[6]) pte_ext[5] = 1'b0;
            op = r[8:7]; rd_is_cap = r[9]; wr_is_cap = r[10];
            priv = (r[15:12] == 0) ? 2'(2 + r[16]) : 2'(r[11]);
            mxr = r[17]; sum = r[18];
            sup_ctrl = r[22:19]; mach_ctrl = r[26:23]; acc_in = r[28:27];
            run_vec();
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule